// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Engine

This block keeps the transmit and receive buffer descriptors of an Ethernet MAC in one local table and moves ownership of them between the host and the MAC datapath. Each descriptor is a status word and a buffer pointer word. The host reads and writes them through a byte-addressed register port. A programmable count divides the table. The lower part is the transmit ring and the rest is the receive ring. Within each ring a wrap bit on a descriptor sends the walk back to the start of that ring.

On the transmit side the engine waits for the host to mark the current descriptor ready. It then presents the buffer pointer, the length and the per-frame options to the MAC. It waits for the completion status, writes that status back and returns the descriptor to the host. On the receive side it shows the MAC whether the current descriptor is free and where its buffer lies. When a frame finishes it writes back the length and error flags. If no free descriptor is available, it drops the frame and flags that.

Every event sets a bit in an interrupt source register. A source bit latches whether or not it is masked. The host clears source bits by writing ones to them, and a mask selects which bits drive the interrupt line.

Top module: `bd_ring_engine`

## Requirements
- R1: Register map, byte addressed: 0x00 is the interrupt source, 0x04 is the interrupt mask (bits 6:0), 0x08 is the transmit count. Descriptor i is at 0x400 + 8*i, with its status word at +0 and its buffer pointer at +4. All registers and descriptors are zero after reset.
- R2: A write of the transmit count stores min(value, NUM_BD). Descriptors 0 to count-1 form the transmit ring and count to NUM_BD-1 form the receive ring. The write restarts the transmit walk at index 0, abandons any transmit request in progress, and restarts the receive walk at index count.
- R3: Status word fields: length in bits 31:16, ownership in bit 15 (1 = ready to send on transmit, 1 = empty on receive), interrupt enable in bit 14, wrap in bit 13. On transmit, bit 12 requests padding and bit 11 requests CRC insertion.
- R4: When the current transmit descriptor has bit 15 set, txq_valid_o rises with the pointer, the length and the pad and CRC flags of that descriptor, and it stays high until txq_ready_i is seen. No further request is made until txc_valid_i reports completion.
- R5: On transmit completion the engine clears bit 15 and replaces bits 8:0 with txc_status_i. All other bits are kept.
- R6: If the completed transmit descriptor has bit 14 set, source bit 1 is set when any of status bits 0, 2, 3 or 8 is 1. Otherwise source bit 0 is set. If bit 14 is clear, neither bit is set.
- R7: After a transmit completion the walk moves to index 0 when the descriptor had wrap set or was the last transmit index. Otherwise it moves to the next index.
- R8: rx_ready_o is 1 exactly when the current receive descriptor has bit 15 set, and rx_ptr_o gives its pointer. On rxd_valid_i a free descriptor receives the length in bits 31:16, bit 15 cleared, and rxd_status_i in bits 8:0. Bits 14:9 are kept.
- R9: If the filled receive descriptor has bit 14 set, the engine sets source bit 3 when any of status bits 7:0 is 1. Otherwise it sets source bit 6 when status bit 8 is 1, and source bit 2 when it is 0.
- R10: A frame reported while the current receive descriptor is not free, or while the receive ring is empty, sets source bit 4 whatever the mask is. The descriptor and the receive position stay unchanged.
- R11: After a filled receive descriptor the walk moves to index count when the descriptor had wrap set or was the last table entry. Otherwise it moves to the next index.
- R12: A pulse on txctl_i sets source bit 5.
- R13: Source bits latch whatever the mask is. irq_o is the OR of source AND mask. Writing 1 to a source bit clears it, and a set in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register or descriptor word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt request |
| txq_valid_o | output | 1 | Transmit request pending |
| txq_ready_i | input | 1 | MAC accepts the transmit request |
| txq_ptr_o | output | 32 | Buffer pointer of the request |
| txq_len_o | output | 16 | Frame length of the request |
| txq_crc_o | output | 1 | Insert CRC |
| txq_pad_o | output | 1 | Pad short frame |
| txc_valid_i | input | 1 | Transmit completion strobe |
| txc_status_i | input | 9 | Transmit completion status |
| txctl_i | input | 1 | Transmit control frame sent |
| rx_ready_o | output | 1 | Current receive descriptor is free |
| rx_ptr_o | output | 32 | Buffer pointer of the current receive descriptor |
| rxd_valid_i | input | 1 | Receive frame finished strobe |
| rxd_len_i | input | 16 | Received frame length |
| rxd_status_i | input | 9 | Receive status flags |

## Verification
The bench builds the engine with NUM_BD = 8 and a transmit count of 4. With these values a walk around either ring takes only a few frames. The transmit ring is cut short by a wrap bit on descriptor 2, and the receive ring wraps at the last table entry back to index 4. The small table also makes the count clamp reachable with a value of 200. Random lengths, status flags and interrupt-enable bits drive every source bit. Directed steps cover a full receive ring, masking and the clear-on-write behaviour.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
  localparam int BD_BASE  = 'h400;
  localparam int OWN_BIT  = 15;
  localparam int IEN_BIT  = 14;
  localparam int WRAP_BIT = 13;
  localparam int PAD_BIT  = 12;
  localparam int CRC_BIT  = 11;
  localparam int SRC_W    = 7;

  localparam int SRC_TXF  = 0;
  localparam int SRC_TXE  = 1;
  localparam int SRC_RXF  = 2;
  localparam int SRC_RXE  = 3;
  localparam int SRC_BUSY = 4;
  localparam int SRC_TXC  = 5;
  localparam int SRC_RXC  = 6;

  localparam logic [31:0] TX_ERR_MASK = 32'h0000_010D;
  localparam logic [31:0] TX_WB_CLR   = 32'h0000_81FF;

  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_WAIT} tx_state_e;
endpackage

// File: rtl/bd_table.sv
module bd_table #(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic             host_word_i,
  input  logic [IDX_W-1:0] host_idx_i,
  input  logic [31:0]      host_data_i,
  input  logic             tx_we_i,
  input  logic [IDX_W-1:0] tx_idx_i,
  input  logic [31:0]      tx_data_i,
  input  logic             rx_we_i,
  input  logic [IDX_W-1:0] rx_idx_i,
  input  logic [31:0]      rx_data_i,
  output logic [31:0]      host_stat_o,
  output logic [31:0]      host_ptr_o,
  output logic [31:0]      tx_stat_o,
  output logic [31:0]      tx_ptr_o,
  output logic [31:0]      rx_stat_o,
  output logic [31:0]      rx_ptr_o
);
  logic [31:0] stat_q [NUM_BD];
  logic [31:0] ptr_q  [NUM_BD];

  for (genvar g = 0; g < NUM_BD; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q[g] <= '0;
      end else if (rx_we_i && rx_idx_i == IDX_W'(g)) begin
        stat_q[g] <= rx_data_i;
      end else if (tx_we_i && tx_idx_i == IDX_W'(g)) begin
        stat_q[g] <= tx_data_i;
      end else if (host_we_i && !host_word_i && host_idx_i == IDX_W'(g)) begin
        stat_q[g] <= host_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q[g] <= '0;
      end else if (host_we_i && host_word_i && host_idx_i == IDX_W'(g)) begin
        ptr_q[g] <= host_data_i;
      end
    end
  end

  assign host_stat_o = stat_q[host_idx_i];
  assign host_ptr_o  = ptr_q[host_idx_i];
  assign tx_stat_o   = stat_q[tx_idx_i];
  assign tx_ptr_o    = ptr_q[tx_idx_i];
  assign rx_stat_o   = stat_q[rx_idx_i];
  assign rx_ptr_o    = ptr_q[rx_idx_i];
endmodule

// File: rtl/bd_irq_regs.sv
module bd_irq_regs
  import bd_ring_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int CNT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             sel_src_i,
  input  logic             sel_mask_i,
  input  logic             sel_cnt_i,
  input  logic [31:0]      wdata_i,
  input  logic [SRC_W-1:0] set_i,
  output logic [SRC_W-1:0] src_o,
  output logic [SRC_W-1:0] mask_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_new_o,
  output logic             irq_o
);
  logic [SRC_W-1:0] src_q, mask_q, clr;
  logic [CNT_W-1:0] cnt_q;

  assign cnt_new_o  = (wdata_i > 32'(NUM_BD)) ? CNT_W'(NUM_BD) : wdata_i[CNT_W-1:0];
  assign cnt_load_o = wr_i && sel_cnt_i;
  assign clr        = (wr_i && sel_src_i) ? wdata_i[SRC_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
    end else begin
      src_q <= (src_q & ~clr) | set_i;
      if (wr_i && sel_mask_i) mask_q <= wdata_i[SRC_W-1:0];
      if (cnt_load_o) cnt_q <= cnt_new_o;
    end
  end

  assign src_o  = src_q;
  assign mask_o = mask_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = |(src_q & mask_q);
endmodule

// File: rtl/bd_tx_ctrl.sv
module bd_tx_ctrl
  import bd_ring_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_load_i,
  input  logic [31:0]      stat_i,
  input  logic [31:0]      ptr_i,
  input  logic             txq_ready_i,
  input  logic             txc_valid_i,
  input  logic [8:0]       txc_status_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             txq_valid_o,
  output logic [31:0]      txq_ptr_o,
  output logic [15:0]      txq_len_o,
  output logic             txq_crc_o,
  output logic             txq_pad_o,
  output logic             wb_we_o,
  output logic [31:0]      wb_data_o,
  output logic             set_txf_o,
  output logic             set_txe_o
);
  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             last, done, err, in_ring;

  assign in_ring = (cnt_i != '0) && (CNT_W'(idx_q) < cnt_i);
  assign last    = CNT_W'(idx_q) == (cnt_i - CNT_W'(1));
  assign idx_nxt = (stat_i[WRAP_BIT] || last) ? '0 : idx_q + IDX_W'(1);
  assign done    = (state_q == TX_WAIT) && txc_valid_i;
  assign err     = |({23'b0, txc_status_i} & TX_ERR_MASK);

  assign txq_valid_o = state_q == TX_REQ;
  assign txq_ptr_o   = ptr_i;
  assign txq_len_o   = stat_i[31:16];
  assign txq_crc_o   = stat_i[CRC_BIT];
  assign txq_pad_o   = stat_i[PAD_BIT];

  assign wb_we_o   = done;
  assign wb_data_o = (stat_i & ~TX_WB_CLR) | {23'b0, txc_status_i};
  assign set_txf_o = done && stat_i[IEN_BIT] && !err;
  assign set_txe_o = done && stat_i[IEN_BIT] && err;
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
    end else if (cnt_load_i) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (in_ring && stat_i[OWN_BIT]) state_q <= TX_REQ;
        TX_REQ:  if (txq_ready_i) state_q <= TX_WAIT;
        TX_WAIT: if (txc_valid_i) begin
          state_q <= TX_IDLE;
          idx_q   <= idx_nxt;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bd_rx_ctrl.sv
module bd_rx_ctrl
  import bd_ring_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = 7,
  parameter int CNT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_new_i,
  input  logic [31:0]      stat_i,
  input  logic             rxd_valid_i,
  input  logic [15:0]      rxd_len_i,
  input  logic [8:0]       rxd_status_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             rx_ready_o,
  output logic             wb_we_o,
  output logic [31:0]      wb_data_o,
  output logic             set_rxf_o,
  output logic             set_rxe_o,
  output logic             set_rxc_o,
  output logic             set_busy_o
);
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             ring_ok, take, err, ien;

  assign ring_ok    = cnt_i < CNT_W'(NUM_BD);
  assign rx_ready_o = ring_ok && stat_i[OWN_BIT];
  assign take       = rxd_valid_i && rx_ready_o;
  assign err        = |rxd_status_i[7:0];
  assign ien        = stat_i[IEN_BIT];
  assign idx_nxt    = (stat_i[WRAP_BIT] || idx_q == IDX_W'(NUM_BD - 1))
                      ? cnt_i[IDX_W-1:0] : idx_q + IDX_W'(1);

  assign wb_we_o    = take;
  assign wb_data_o  = {rxd_len_i, 1'b0, stat_i[14:9], rxd_status_i};
  assign set_rxe_o  = take && ien && err;
  assign set_rxc_o  = take && ien && !err && rxd_status_i[8];
  assign set_rxf_o  = take && ien && !err && !rxd_status_i[8];
  assign set_busy_o = rxd_valid_i && !rx_ready_o;
  assign idx_o      = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         idx_q <= '0;
    else if (cnt_load_i) idx_q <= cnt_new_i[IDX_W-1:0];
    else if (take)       idx_q <= idx_nxt;
  end
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine
  import bd_ring_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int ADDR_W = $clog2(BD_BASE + NUM_BD * 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              txq_valid_o,
  input  logic              txq_ready_i,
  output logic [31:0]       txq_ptr_o,
  output logic [15:0]       txq_len_o,
  output logic              txq_crc_o,
  output logic              txq_pad_o,
  input  logic              txc_valid_i,
  input  logic [8:0]        txc_status_i,
  input  logic              txctl_i,
  output logic              rx_ready_o,
  output logic [31:0]       rx_ptr_o,
  input  logic              rxd_valid_i,
  input  logic [15:0]       rxd_len_i,
  input  logic [8:0]        rxd_status_i
);
  localparam int IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1;
  localparam int CNT_W = $clog2(NUM_BD + 1);
  localparam int REG_W = ADDR_W - 2;

  logic [ADDR_W-1:0] bd_off;
  logic              is_bd, sel_src, sel_mask, sel_cnt;
  logic [IDX_W-1:0]  host_idx, tx_idx, rx_idx;
  logic [31:0]       host_stat, host_ptr, tx_stat, tx_ptr, rx_stat;
  logic [31:0]       tx_wb_data, rx_wb_data;
  logic              tx_wb_we, rx_wb_we;
  logic [SRC_W-1:0]  src, mask, set;
  logic [CNT_W-1:0]  cnt, cnt_new;
  logic              cnt_load;
  logic              s_txf, s_txe, s_rxf, s_rxe, s_rxc, s_busy;

  // address decode
  assign bd_off   = reg_addr_i - ADDR_W'(BD_BASE);
  assign is_bd    = (reg_addr_i >= ADDR_W'(BD_BASE)) &&
                    (bd_off[ADDR_W-1:3] < (ADDR_W-3)'(NUM_BD));
  assign host_idx = bd_off[3 +: IDX_W];
  assign sel_src  = reg_addr_i[ADDR_W-1:2] == REG_W'(0);
  assign sel_mask = reg_addr_i[ADDR_W-1:2] == REG_W'(1);
  assign sel_cnt  = reg_addr_i[ADDR_W-1:2] == REG_W'(2);

  always_comb begin
    reg_rdata_o = '0;
    if (is_bd)         reg_rdata_o = bd_off[2] ? host_ptr : host_stat;
    else if (sel_src)  reg_rdata_o = 32'(src);
    else if (sel_mask) reg_rdata_o = 32'(mask);
    else if (sel_cnt)  reg_rdata_o = 32'(cnt);
  end

  always_comb begin
    set           = '0;
    set[SRC_TXF]  = s_txf;
    set[SRC_TXE]  = s_txe;
    set[SRC_RXF]  = s_rxf;
    set[SRC_RXE]  = s_rxe;
    set[SRC_BUSY] = s_busy;
    set[SRC_TXC]  = txctl_i;
    set[SRC_RXC]  = s_rxc;
  end

  bd_table #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (reg_wr_i && is_bd),
    .host_word_i (bd_off[2]),
    .host_idx_i  (host_idx),
    .host_data_i (reg_wdata_i),
    .tx_we_i     (tx_wb_we),
    .tx_idx_i    (tx_idx),
    .tx_data_i   (tx_wb_data),
    .rx_we_i     (rx_wb_we),
    .rx_idx_i    (rx_idx),
    .rx_data_i   (rx_wb_data),
    .host_stat_o (host_stat),
    .host_ptr_o  (host_ptr),
    .tx_stat_o   (tx_stat),
    .tx_ptr_o    (tx_ptr),
    .rx_stat_o   (rx_stat),
    .rx_ptr_o    (rx_ptr_o)
  );

  bd_irq_regs #(.NUM_BD(NUM_BD), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i && !is_bd),
    .sel_src_i  (sel_src),
    .sel_mask_i (sel_mask),
    .sel_cnt_i  (sel_cnt),
    .wdata_i    (reg_wdata_i),
    .set_i      (set),
    .src_o      (src),
    .mask_o     (mask),
    .cnt_o      (cnt),
    .cnt_load_o (cnt_load),
    .cnt_new_o  (cnt_new),
    .irq_o      (irq_o)
  );

  bd_tx_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_i        (cnt),
    .cnt_load_i   (cnt_load),
    .stat_i       (tx_stat),
    .ptr_i        (tx_ptr),
    .txq_ready_i  (txq_ready_i),
    .txc_valid_i  (txc_valid_i),
    .txc_status_i (txc_status_i),
    .idx_o        (tx_idx),
    .txq_valid_o  (txq_valid_o),
    .txq_ptr_o    (txq_ptr_o),
    .txq_len_o    (txq_len_o),
    .txq_crc_o    (txq_crc_o),
    .txq_pad_o    (txq_pad_o),
    .wb_we_o      (tx_wb_we),
    .wb_data_o    (tx_wb_data),
    .set_txf_o    (s_txf),
    .set_txe_o    (s_txe)
  );

  bd_rx_ctrl #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_i        (cnt),
    .cnt_load_i   (cnt_load),
    .cnt_new_i    (cnt_new),
    .stat_i       (rx_stat),
    .rxd_valid_i  (rxd_valid_i),
    .rxd_len_i    (rxd_len_i),
    .rxd_status_i (rxd_status_i),
    .idx_o        (rx_idx),
    .rx_ready_o   (rx_ready_o),
    .wb_we_o      (rx_wb_we),
    .wb_data_o    (rx_wb_data),
    .set_rxf_o    (s_rxf),
    .set_rxe_o    (s_rxe),
    .set_rxc_o    (s_rxc),
    .set_busy_o   (s_busy)
  );
endmodule

// File: rtl/bd_ring_chk.sv
module bd_ring_chk #(
  parameter int NUM_BD = 128,
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              txq_valid_o,
  input logic              txq_ready_i,
  input logic              txc_valid_i,
  input logic              rxd_valid_i,
  input logic              txctl_i,
  input logic              rx_ready_o,
  input logic [6:0]        src,
  input logic [CNT_W-1:0]  cnt
);
  logic cnt_wr, src_wr;
  assign cnt_wr = reg_wr_i && reg_addr_i == ADDR_W'(8);
  assign src_wr = reg_wr_i && reg_addr_i == ADDR_W'(0);

  // R4
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txq_valid_o && !txq_ready_i && !cnt_wr |=> txq_valid_o);

  // R4
  tx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txq_valid_o && txq_ready_i |=> !txq_valid_o);

  // R10
  rx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxd_valid_i && !rx_ready_o |=> src[4]);

  // R13
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_wr && reg_wdata_i[6:0] == 7'h7f && !txc_valid_i && !rxd_valid_i && !txctl_i
    |=> src == 7'h00);

  // R12
  txctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txctl_i |=> src[5]);

  // R2
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(NUM_BD));
endmodule

bind bd_ring_engine bd_ring_chk #(.NUM_BD(NUM_BD), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .txq_valid_o (txq_valid_o),
  .txq_ready_i (txq_ready_i),
  .txc_valid_i (txc_valid_i),
  .rxd_valid_i (rxd_valid_i),
  .txctl_i     (txctl_i),
  .rx_ready_o  (rx_ready_o),
  .src         (src),
  .cnt         (cnt)
);

// File: tb/sim_bd_ring_engine.sv
module sim_bd_ring_engine;
  localparam int NBD = 8;
  localparam int AW  = $clog2(1024 + NBD * 8);
  localparam int TXN = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, txq_valid, txq_ready = 1'b0, txq_crc, txq_pad;
  logic [31:0] txq_ptr, rx_ptr;
  logic [15:0] txq_len, rxd_len = '0;
  logic txc_valid = 1'b0, txctl = 1'b0, rx_ready, rxd_valid = 1'b0;
  logic [8:0] txc_status = '0, rxd_status = '0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mstat [NBD];
  logic [31:0] mptr  [NBD];

  always #5 clk = ~clk;

  bd_ring_engine #(.NUM_BD(NBD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .txq_valid_o(txq_valid), .txq_ready_i(txq_ready), .txq_ptr_o(txq_ptr),
    .txq_len_o(txq_len), .txq_crc_o(txq_crc), .txq_pad_o(txq_pad),
    .txc_valid_i(txc_valid), .txc_status_i(txc_status), .txctl_i(txctl),
    .rx_ready_o(rx_ready), .rx_ptr_o(rx_ptr), .rxd_valid_i(rxd_valid),
    .rxd_len_i(rxd_len), .rxd_status_i(rxd_status));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] tx_wb(input logic [31:0] old, input logic [8:0] st);
    return (old & ~32'h81FF) | {23'b0, st};
  endfunction

  function automatic logic [6:0] tx_src(input logic [31:0] old, input logic [8:0] st);
    if (!old[14]) return 7'h00;
    return (st[0] | st[2] | st[3] | st[8]) ? 7'h02 : 7'h01;
  endfunction

  function automatic logic [6:0] rx_src(input logic [31:0] old, input logic [8:0] st);
    if (!old[14]) return 7'h00;
    if (|st[7:0]) return 7'h08;
    return st[8] ? 7'h40 : 7'h04;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int txi, rxi, w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd('h00, d); chk("R1 src reset", d, 0);
    rd('h04, d); chk("R1 mask reset", d, 0);
    rd('h08, d); chk("R1 count reset", d, 0);
    rd('h400 + 8 * 3, d); chk("R1 desc reset", d, 0);
    chk("R1 irq reset", {31'b0, irq}, 0);
    chk("R4 no request at reset", {31'b0, txq_valid}, 0);

    // R2 clamp
    wr('h08, 200); rd('h08, d); chk("R2 count clamp", d, NBD);
    chk("R10 no rx ring ready", {31'b0, rx_ready}, 0);
    wr('h08, TXN); rd('h08, d); chk("R2 count write", d, TXN);

    for (int i = 0; i < NBD; i++) begin
      mptr[i] = 32'h1000 * i + 32'h100;
      wr('h404 + 8 * i, mptr[i]);
      mstat[i] = (i == 2) ? 32'h0000_6800 : 32'h0000_4800;
      if (i >= TXN) mstat[i] = 32'h0000_C000;
      wr('h400 + 8 * i, mstat[i]);
    end
    rd('h404 + 8 * 5, d); chk("R1 pointer word", d, mptr[5]);

    // R4 nothing ready -> no request
    repeat (4) @(negedge clk);
    chk("R4 idle without ready", {31'b0, txq_valid}, 0);

    // transmit frames around the wrapped ring
    txi = 0;
    for (int f = 0; f < 6; f++) begin
      logic [8:0] st;
      wr('h00, 32'h7F);
      mstat[txi] = {16'($urandom_range(60, 1500)), 1'b1, 1'($urandom), mstat[txi][13],
                    1'($urandom), 1'($urandom), 11'b0};
      wr('h400 + 8 * txi, mstat[txi]);
      w = 0;
      while (!txq_valid && w < 10) begin @(negedge clk); w++; end
      chk("R4 request valid", {31'b0, txq_valid}, 1);
      chk("R4 request ptr", txq_ptr, mptr[txi]);
      chk("R3 request len", {16'b0, txq_len}, {16'b0, mstat[txi][31:16]});
      chk("R3 request flags", {30'b0, txq_pad, txq_crc}, {30'b0, mstat[txi][12:11]});
      repeat (2) @(negedge clk);
      chk("R4 held without ready", {31'b0, txq_valid}, 1);
      txq_ready = 1'b1; @(negedge clk); txq_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk("R4 single outstanding", {31'b0, txq_valid}, 0);
      st = 9'($urandom);
      if (f == 0) st = 9'h0F2;
      if (f == 1) st = 9'h100;
      txc_status = st; txc_valid = 1'b1; @(negedge clk); txc_valid = 1'b0;
      rd('h400 + 8 * txi, d); chk("R5 tx writeback", d, tx_wb(mstat[txi], st));
      rd('h00, d); chk("R6 tx source", d, {25'b0, tx_src(mstat[txi], st)});
      mstat[txi] = tx_wb(mstat[txi], st);
      txi = (mstat[txi][13] || txi == TXN - 1) ? 0 : txi + 1;
      chk("R7 tx walk", txi, (f % 3 == 2) ? 0 : (f % 3) + 1);
    end

    // R13 masking and clear
    wr('h00, 32'h7F);
    txctl = 1'b1; @(negedge clk); txctl = 1'b0;
    rd('h00, d); chk("R12 txctl source", d, 32'h20);
    chk("R13 masked irq", {31'b0, irq}, 0);
    wr('h04, 32'h20); #1 chk("R13 unmasked irq", {31'b0, irq}, 1);
    wr('h00, 32'h20); #1 chk("R13 cleared irq", {31'b0, irq}, 0);

    // receive frames
    rxi = TXN;
    for (int f = 0; f < 6; f++) begin
      logic [8:0] st;
      logic [15:0] ln;
      wr('h00, 32'h7F);
      mstat[rxi] = {16'b0, 1'b1, 1'($urandom), 14'b0};
      if (f < 2) mstat[rxi][14] = 1'b1;
      wr('h400 + 8 * rxi, mstat[rxi]);
      chk("R8 rx ready", {31'b0, rx_ready}, 1);
      chk("R8 rx ptr", rx_ptr, mptr[rxi]);
      st = 9'($urandom);
      if (f == 0) st = 9'h100;
      if (f == 1) st = 9'h000;
      ln = 16'($urandom_range(64, 1518));
      rxd_len = ln; rxd_status = st; rxd_valid = 1'b1;
      @(negedge clk); rxd_valid = 1'b0;
      rd('h400 + 8 * rxi, d);
      chk("R8 rx writeback", d, {ln, 1'b0, mstat[rxi][14:9], st});
      rd('h00, d); chk("R9 rx source", d, {25'b0, rx_src(mstat[rxi], st)});
      mstat[rxi] = {ln, 1'b0, mstat[rxi][14:9], st};
      rxi = (mstat[rxi][13] || rxi == NBD - 1) ? TXN : rxi + 1;
      chk("R11 rx walk", rxi, TXN + ((f + 1) % (NBD - TXN)));
    end

    // R10 drop on full ring
    wr('h00, 32'h7F);
    chk("R10 not ready", {31'b0, rx_ready}, 0);
    rxd_len = 16'd99; rxd_status = 9'h0; rxd_valid = 1'b1;
    @(negedge clk); rxd_valid = 1'b0;
    rd('h00, d); chk("R10 busy source", d, 32'h10);
    rd('h400 + 8 * rxi, d); chk("R10 desc unchanged", d, mstat[rxi]);
    wr('h400 + 8 * rxi, 32'h0000_8000);
    chk("R10 position kept", rx_ptr, mptr[rxi]);

    // R2 restart of the receive walk
    wr('h08, 6);
    wr('h400 + 8 * 6, 32'h0000_8000);
    chk("R2 rx restart ptr", rx_ptr, mptr[6]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule